// File: doc/BRIEF.md
# Hit-pattern acquisition and readout core

This core is the digital back end of one channel-rich sensor readout chip. Each of its 64 discriminator lines sets a sticky hit flag, and the OR of the lines is offered as a fast trigger output. A 12-bit crossing counter advances once per slow-clock period. At each period boundary the core may record one frame into a 128-entry store. A frame holds all 64 flags and the crossing number. The flags are cleared at every boundary, whether or not a frame was written.

A frame is recorded when the validation window is open and at least one flag is set, or when an external trigger has risen since the previous boundary. When the store holds 128 frames, an active-low full flag is driven, and that flag can be wired-OR with other chips. A separate halt input, fed from that shared flag, stops acquisition on every chip at once. A readout request starts the transfer of the stored frames over one serial line, oldest first. Each frame goes out as 76 bits, most significant first. When the store is empty the core pulses a done output, which serves as the next chip's readout request in a daisy chain.

The design runs on one fast clock. A one-cycle strobe marks each slow-clock period, and that strobe paces the crossing counter, frame commits and the serial shift.

Top module: `hitro_core`

## Requirements
- R1: A discriminator line that is high in any cycle sets its flag. A high `flag_clr_i` clears all flags in that cycle and takes priority over hits arriving in the same cycle.
- R2: The crossing counter increments on each `xing_tick_i` and wraps from 4095 to 0. A high `xing_clr_i` forces it to 0 and takes priority over a tick.
- R3: In acquisition, a tick writes a frame if one of two conditions holds: `valid_win_i` is high and any flag is set, or `ext_trig_i` has risen since the previous tick (including a rise in the tick cycle). The frame is {flags[63:0], counter[11:0]}, sampled before that tick updates them. All flags are cleared at every tick.
- R4: `mem_full_n_o` is low exactly while 128 frames are stored. No frame is written while the store is full.
- R5: A high `halt_i` during acquisition ends acquisition. No frame is written until the next `acq_go_i`.
- R6: `acq_go_i` starts acquisition and discards all stored frames.
- R7: `rd_go_i`, outside readout, starts readout in the next cycle with `sending_o` high. `sdata_o` presents each frame's bits from bit 75 (hit 63) down to bit 0 (counter bit 0). The line advances one bit after each tick, and frames leave in the order they were written.
- R8: The tick that consumes the last bit ends readout. In the next cycle `sending_o` falls, `rd_done_o` is high for exactly one cycle, and the store is empty.
- R9: A readout request while the store is empty raises `rd_done_o` for one cycle in the next cycle, and `sending_o` never rises.
- R10: `hit_or_o` is the combinational OR of all 64 discriminator lines.
- R11: `rd_go_i` and `acq_go_i` have no effect while readout is in progress.
- R12: After reset, `sending_o`, `sdata_o` and `rd_done_o` are low, `mem_full_n_o` is high, the counter is 0 and no flag is set. `sdata_o` is low whenever `sending_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State-machine clock |
| rst_n | input | 1 | Synchronous general reset, active low |
| disc_i | input | 64 | Discriminator lines |
| flag_clr_i | input | 1 | Clear all hit flags, active high |
| xing_tick_i | input | 1 | One-cycle strobe per slow-clock period |
| xing_clr_i | input | 1 | Crossing counter reset, active high |
| acq_go_i | input | 1 | Start acquisition, clears the store |
| valid_win_i | input | 1 | Validation window for hit commits |
| ext_trig_i | input | 1 | External trigger, rising edge forces a frame |
| halt_i | input | 1 | External full, stops acquisition |
| rd_go_i | input | 1 | Start readout (token in) |
| hit_or_o | output | 1 | OR of all discriminator lines |
| mem_full_n_o | output | 1 | Store full, active low |
| sdata_o | output | 1 | Serial frame data |
| sending_o | output | 1 | High while frames are being shifted |
| rd_done_o | output | 1 | One-cycle token out at end of readout |

## Verification
The checker watches these output-level rules on every cycle:
- the done pulse is one cycle long and never overlaps transmission;
- the done pulse follows a readout request or the end of a transfer;
- the serial line is quiet outside readout and holds steady between ticks;
- a full store stays full until it is cleared or drained;
- a readout request during transfer neither restarts it nor cuts it short.

Only the bench scenarios can show that the correct frames are recorded and shifted out in order. That covers the validation gating, forced trigger frames, counter wrap and clear, the fill to exactly 128 frames, halt and restart. The bench checks these bit for bit against a behavioural queue model.

// File: rtl/hitro_pkg.sv
package hitro_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_READ = 2'd2
    } rd_state_e;

endpackage

// File: rtl/hitro_flags.sv
module hitro_flags #(
    parameter int N_CH = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] disc_i,
    input  logic            clr_i,
    input  logic            tick_i,
    output logic [N_CH-1:0] flags_o,
    output logic            any_o,
    output logic            or_o
);

    typedef struct packed {
        logic [N_CH-1:0] flag;
    } flag_t;

    flag_t q, d;

    always_comb begin
        d = q;
        if (clr_i) begin
            d.flag = '0;
        end else begin
            d.flag = (tick_i ? '0 : q.flag) | disc_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign flags_o = q.flag;
    assign any_o   = |q.flag;
    assign or_o    = |disc_i;

endmodule

// File: rtl/hitro_xcount.sv
module hitro_xcount #(
    parameter int XW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          tick_i,
    output logic [XW-1:0] count_o
);

    typedef struct packed {
        logic [XW-1:0] cnt;
    } cnt_t;

    cnt_t q, d;

    always_comb begin
        d = q;
        if (clr_i) begin
            d.cnt = '0;
        end else if (tick_i) begin
            d.cnt = q.cnt + XW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign count_o = q.cnt;

endmodule

// File: rtl/hitro_store.sv
module hitro_store #(
    parameter int DEPTH = 128,
    parameter int FW    = 76,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [FW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [FW-1:0] rdata_o
);

    logic [FW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/hitro_core.sv
module hitro_core
    import hitro_pkg::*;
#(
    parameter int N_CH  = 64,
    parameter int XW    = 12,
    parameter int DEPTH = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] disc_i,
    input  logic            flag_clr_i,
    input  logic            xing_tick_i,
    input  logic            xing_clr_i,
    input  logic            acq_go_i,
    input  logic            valid_win_i,
    input  logic            ext_trig_i,
    input  logic            halt_i,
    input  logic            rd_go_i,
    output logic            hit_or_o,
    output logic            mem_full_n_o,
    output logic            sdata_o,
    output logic            sending_o,
    output logic            rd_done_o
);

    localparam int FW  = N_CH + XW;
    localparam int AW  = $clog2(DEPTH);
    localparam int PW  = AW + 1;
    localparam int BCW = $clog2(FW);

    typedef struct packed {
        rd_state_e      state;
        logic [PW-1:0]  wptr;
        logic [PW-1:0]  rptr;
        logic [BCW-1:0] bitcnt;
        logic [FW-1:0]  sh;
        logic           pend;
        logic           prev;
        logic           done;
    } ctrl_t;

    ctrl_t q, d;

    logic [N_CH-1:0] flags;
    logic            any_flag;
    logic [XW-1:0]   xcount;
    logic [FW-1:0]   rdata;
    logic [AW-1:0]   raddr;
    logic            we;
    logic            full;
    logic            trig_edge;
    logic            force_rec;

    hitro_flags #(.N_CH(N_CH)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .disc_i  (disc_i),
        .clr_i   (flag_clr_i),
        .tick_i  (xing_tick_i),
        .flags_o (flags),
        .any_o   (any_flag),
        .or_o    (hit_or_o)
    );

    hitro_xcount #(.XW(XW)) u_xcount (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (xing_clr_i),
        .tick_i  (xing_tick_i),
        .count_o (xcount)
    );

    hitro_store #(.DEPTH(DEPTH), .FW(FW)) u_store (
        .clk     (clk),
        .we_i    (we),
        .waddr_i (q.wptr[AW-1:0]),
        .wdata_i ({flags, xcount}),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        we        = 1'b0;
        full      = (q.wptr == PW'(DEPTH));
        trig_edge = ext_trig_i & ~q.prev;
        force_rec = q.pend | trig_edge;
        raddr     = (q.state == ST_READ) ? (q.rptr[AW-1:0] + AW'(1)) : '0;

        if (rd_go_i && q.state != ST_READ) begin
            // token arrives: drain what is stored, or pass it on at once
            if (q.wptr == '0) begin
                d.state = ST_IDLE;
                d.done  = 1'b1;
            end else begin
                d.state  = ST_READ;
                d.sh     = rdata;
                d.rptr   = '0;
                d.bitcnt = '0;
            end
        end else begin
            case (q.state)
                ST_IDLE: begin
                    if (acq_go_i) begin
                        d.state = ST_ACQ;
                        d.wptr  = '0;
                    end
                end
                ST_ACQ: begin
                    if (halt_i) begin
                        d.state = ST_IDLE;
                    end else if (acq_go_i) begin
                        d.wptr = '0;
                    end else if (xing_tick_i && !full &&
                                 ((valid_win_i && any_flag) || force_rec)) begin
                        we     = 1'b1;
                        d.wptr = q.wptr + PW'(1);
                    end
                end
                ST_READ: begin
                    if (xing_tick_i) begin
                        if (q.bitcnt == BCW'(FW - 1)) begin
                            if (q.rptr + PW'(1) == q.wptr) begin
                                d.state = ST_IDLE;
                                d.done  = 1'b1;
                                d.wptr  = '0;
                                d.rptr  = '0;
                            end else begin
                                d.rptr   = q.rptr + PW'(1);
                                d.sh     = rdata;
                                d.bitcnt = '0;
                            end
                        end else begin
                            d.sh     = {q.sh[FW-2:0], 1'b0};
                            d.bitcnt = q.bitcnt + BCW'(1);
                        end
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end

        d.pend = xing_tick_i ? 1'b0 : force_rec;
        d.prev = ext_trig_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sending_o    = (q.state == ST_READ);
    assign sdata_o      = sending_o & q.sh[FW-1];
    assign rd_done_o    = q.done;
    assign mem_full_n_o = ~full;

endmodule

// File: rtl/hitro_core_chk.sv
module hitro_core_chk (
    input logic clk,
    input logic rst_n,
    input logic acq_go_i,
    input logic rd_go_i,
    input logic xing_tick_i,
    input logic mem_full_n_o,
    input logic sdata_o,
    input logic sending_o,
    input logic rd_done_o
);

    // R8: token out only once shifting has stopped
    a_r8_done_not_sending: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done_o |-> !sending_o);

    // R8: token out lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done_o |=> !rd_done_o);

    // R9: token out follows a request or the end of a transfer
    a_r9_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done_o |-> ($past(rd_go_i) || $past(sending_o)));

    // R12: serial line quiet outside readout
    a_r12_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
        !sending_o |-> !sdata_o);

    // R7: line only moves on a tick
    a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (sending_o && !xing_tick_i) |=> (sending_o && $stable(sdata_o)));

    // R11: a request during readout neither restarts nor aborts it
    a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (sending_o && (rd_go_i || acq_go_i)) |=> (sending_o || rd_done_o));

    // R4: a full store stays full until restarted or drained
    a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_full_n_o && !acq_go_i) |=> (!mem_full_n_o || rd_done_o));

endmodule

bind hitro_core hitro_core_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acq_go_i     (acq_go_i),
    .rd_go_i      (rd_go_i),
    .xing_tick_i  (xing_tick_i),
    .mem_full_n_o (mem_full_n_o),
    .sdata_o      (sdata_o),
    .sending_o    (sending_o),
    .rd_done_o    (rd_done_o)
);

// File: tb/test_hitro_core.sv
`timescale 1ns/1ps
module test_hitro_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] disc = '0;
    logic        flag_clr = 0, tick = 0, xclr = 0, acq_go = 0, valid = 0;
    logic        ext_trig = 0, halt = 0, rd_go = 0;
    logic        hit_or, full_n, sdata, sending, rd_done;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit cmp_en = 0;
    string cur_req = "R12";

    always #2 clk = ~clk;

    hitro_core i_hitro_core (
        .clk(clk), .rst_n(rst_n), .disc_i(disc), .flag_clr_i(flag_clr),
        .xing_tick_i(tick), .xing_clr_i(xclr), .acq_go_i(acq_go),
        .valid_win_i(valid), .ext_trig_i(ext_trig), .halt_i(halt),
        .rd_go_i(rd_go), .hit_or_o(hit_or), .mem_full_n_o(full_n),
        .sdata_o(sdata), .sending_o(sending), .rd_done_o(rd_done)
    );

    // ---------------- behavioural reference model ----------------
    logic [63:0] m_flags;
    int          m_bx;
    bit          m_pend, m_prev, m_done;
    int          m_state;          // 0 idle, 1 acquiring, 2 reading
    logic [75:0] m_mem[$];
    bit          m_bits[$];

    always @(posedge clk) begin : model
        bit edge_now, force_now;
        if (!rst_n) begin
            m_flags = '0; m_bx = 0; m_pend = 0; m_prev = 0; m_done = 0;
            m_state = 0; m_mem.delete(); m_bits.delete();
        end else begin
            edge_now  = ext_trig && !m_prev;
            force_now = m_pend || edge_now;
            m_done    = 0;
            if (rd_go && m_state != 2) begin
                if (m_mem.size() == 0) begin
                    m_done = 1; m_state = 0;
                end else begin
                    m_bits.delete();
                    foreach (m_mem[k])
                        for (int b = 75; b >= 0; b--) m_bits.push_back(m_mem[k][b]);
                    m_state = 2;
                end
            end else if (m_state == 0) begin
                if (acq_go) begin m_mem.delete(); m_state = 1; end
            end else if (m_state == 1) begin
                if (halt) m_state = 0;
                else if (acq_go) m_mem.delete();
                else if (tick && m_mem.size() < 128 &&
                         ((valid && m_flags != 0) || force_now))
                    m_mem.push_back({m_flags, 12'(m_bx)});
            end else begin
                if (tick) begin
                    void'(m_bits.pop_front());
                    if (m_bits.size() == 0) begin
                        m_state = 0; m_done = 1; m_mem.delete();
                    end
                end
            end
            m_pend  = tick ? 0 : force_now;
            m_prev  = ext_trig;
            m_flags = flag_clr ? '0 : ((tick ? 64'd0 : m_flags) | disc);
            m_bx    = xclr ? 0 : (tick ? (m_bx + 1) % 4096 : m_bx);
        end
    end

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && cmp_en && !finished) begin
            chk({"R10 ", cur_req}, "hit_or", 64'(hit_or), 64'(|disc));
            chk({"R4 ", cur_req}, "full_n", 64'(full_n), 64'(m_mem.size() != 128));
            chk({"R8 ", cur_req}, "rd_done", 64'(rd_done), 64'(m_done));
            chk({"R7 ", cur_req}, "sending", 64'(sending), 64'(m_state == 2));
            chk({"R7 ", cur_req}, "sdata", 64'(sdata),
                64'((m_state == 2 && m_bits.size() > 0) ? m_bits[0] : 1'b0));
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic pulse_tick();
        tick = 1; step(); tick = 0;
    endtask

    task automatic read_all(string req, int exp_frames);
        int dones = 0;
        int guard = 0;
        cur_req = req;
        chk(req, "frames stored before read", 64'(m_mem.size()), 64'(exp_frames));
        rd_go = 1; step(); rd_go = 0;
        if (rd_done) dones++;
        while (m_state == 2 && guard < 12000) begin
            tick = 1; step(); guard++;
            if (rd_done) dones++;
        end
        tick = 0;
        chk(req, "token out pulses", 64'(dones), 64'd1);
        chk(req, "sending low after read", 64'(sending), 64'd0);
        chk(req, "store empty after read", 64'(full_n), 64'd1);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: actual=expired expected=done");
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        step(4);
        rst_n = 1; step();
        cmp_en = 1;
        // R12 reset state
        chk("R12", "sending", 64'(sending), 0);
        chk("R12", "sdata", 64'(sdata), 0);
        chk("R12", "rd_done", 64'(rd_done), 0);
        chk("R12", "full_n", 64'(full_n), 1);

        // R10 OR of discriminator lines
        cur_req = "R10";
        disc = 64'h1; step();
        disc = 64'h8000_0000_0000_0000; step();
        disc = '0; step();

        // R9 empty readout passes the token on at once
        read_all("R9", 0);

        // R1 flag clear beats a simultaneous hit
        cur_req = "R1";
        acq_go = 1; step(); acq_go = 0;
        valid = 1;
        disc = 64'h20; step(); disc = 64'h40; flag_clr = 1; step();
        flag_clr = 0; disc = '0; pulse_tick();
        disc = 64'h0000_0100_0000_0001; step(); disc = '0; pulse_tick();
        read_all("R1", 1);

        // R3 commits: gated hits, ungated hits, forced frames
        cur_req = "R3";
        acq_go = 1; step(); acq_go = 0;
        for (int i = 0; i < 6; i++) begin
            disc = {$urandom(), $urandom()}; step(); disc = '0; pulse_tick();
        end
        valid = 0;
        disc = 64'hFFFF; step(); disc = '0; pulse_tick();     // dropped
        ext_trig = 1; step(); ext_trig = 0; step(2); pulse_tick(); // forced
        ext_trig = 1; tick = 1; step(); tick = 0; ext_trig = 0;     // edge in tick cycle
        pulse_tick();                                             // nothing pending
        valid = 1;
        disc = 64'h5; tick = 1; step(); tick = 0; disc = '0;      // hit in tick cycle not in frame
        pulse_tick();
        read_all("R3", 9);

        // R11 requests during readout are ignored
        cur_req = "R11";
        acq_go = 1; step(); acq_go = 0;
        disc = 64'hA5; step(); disc = '0; pulse_tick();
        rd_go = 1; step(); rd_go = 0;
        for (int i = 0; i < 10; i++) begin
            tick = (i % 2 == 0); rd_go = (i == 3); acq_go = (i == 6); step();
        end
        tick = 0; rd_go = 0; acq_go = 0;
        while (m_state == 2) pulse_tick();
        chk("R11", "token after ignored requests", 64'(full_n), 1);

        // R2 counter clear and wrap
        cur_req = "R2";
        xclr = 1; tick = 1; step(); xclr = 0; tick = 0;
        tick = 1; step(4094); tick = 0;
        acq_go = 1; step(); acq_go = 0;
        disc = 64'h3; step(); disc = '0; pulse_tick();     // count 4094
        disc = 64'h7; step(); disc = '0; pulse_tick();     // count 4095
        disc = 64'hF; step(); disc = '0; pulse_tick();     // count 0
        xclr = 1; step(); xclr = 0;
        disc = 64'h1F; step(); disc = '0; pulse_tick();    // count 0 again
        read_all("R2", 4);

        // R5 halt stops acquisition
        cur_req = "R5";
        acq_go = 1; step(); acq_go = 0;
        disc = 64'h9; step(); disc = '0; pulse_tick();
        halt = 1; step(); halt = 0;
        for (int i = 0; i < 3; i++) begin
            disc = 64'hFF; step(); disc = '0; pulse_tick();
        end
        read_all("R5", 1);

        // R6 restart discards stored frames
        cur_req = "R6";
        acq_go = 1; step(); acq_go = 0;
        for (int i = 0; i < 3; i++) begin
            disc = 64'(i + 1); step(); disc = '0; pulse_tick();
        end
        acq_go = 1; step(); acq_go = 0;
        disc = 64'hC0DE; step(); disc = '0; pulse_tick();
        read_all("R6", 1);

        // R4 fill to 128 frames, extra hits dropped
        cur_req = "R4";
        acq_go = 1; step(); acq_go = 0;
        for (int i = 0; i < 132; i++) begin
            disc = {$urandom(), $urandom()} | 64'h1; tick = 1; step();
            tick = 0; disc = '0; step();
        end
        chk("R4", "full flag low", 64'(full_n), 0);
        halt = 1; step(); halt = 0;
        chk("R4", "full survives halt", 64'(full_n), 0);
        read_all("R8", 128);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule